// File: doc/BRIEF.md
# Tearing-Effect Synchronized Transfer Gate

This block decides when a display pixel-data transfer may begin. Each transfer command arrives over a valid/ready handshake and carries a data length and a 2-bit synchronization mode. A command with no synchronization starts at once. A synchronized command is held until the panel's tearing-effect (TE) signal shows the selected edge. The block then waits a programmable delay before it pulses a start strobe to the downstream bus shifter, together with the command's length.

The delay is counted in ticks of a two-stage prescaler. The first stage divides the controller clock by 2^R0. The second stage divides the first stage's output by 2^R1. The delay lasts WAIT ticks of the second stage. Both prescaler stages run freely while nothing waits. They restart from zero when the qualifying TE edge arrives, so the delay is exact no matter how long the block sat idle. Software sets a nonzero mode only on the first chunk of a new frame. Continuation chunks, which can be up to 0x40000 bytes each, and command or parameter writes use mode 0 and go straight through.

Top module: `te_sync_gate`

## Requirements
- R1: After reset, `busy_o` is 0, `cmd_ready_o` is 1 and `xfer_start_o` is 0.
- R2: A command with mode 0 is accepted while idle. `xfer_start_o` is high in the cycle that follows the accepting clock edge, and `xfer_len_o` holds the command's length. Back-to-back mode-0 commands each start in this way.
- R3: Mode 3 is reserved and behaves like mode 0: it starts immediately and never waits for TE.
- R4: Mode 1 waits for a rising TE edge and ignores falling edges. The TE pin passes through two synchronizer flops. If the pin rises between two clock edges, `xfer_start_o` is high in the cycle after the (3 + WAIT·2^(R0+R1))-th clock edge that follows.
- R5: Mode 2 waits for a falling TE edge, with the same timing as R4, and ignores rising edges.
- R6: With WAIT = 0, a synchronized command starts in the cycle after the 3rd clock edge that follows the qualifying pin edge.
- R7: A TE edge is ignored if it reaches the edge detector at or before the clock edge that accepts the command. Only a later edge starts the transfer.
- R8: `busy_o` is high from the accepting edge of a synchronized command until the start strobe, and falls together with it. While `busy_o` is high, `cmd_ready_o` is 0 and any offered command is not taken.
- R9: `xfer_start_o` is a single-cycle pulse for each command. `xfer_len_o` carries the length unchanged, including the maximum of 0x40000 (19-bit field).
- R10: The delay after the qualifying edge does not depend on how long the block was idle before, because both prescaler stages restart at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| te_pin_i | input | 1 | Asynchronous tearing-effect input from the panel |
| cmd_valid_i | input | 1 | Transfer command offered |
| cmd_ready_o | output | 1 | Command taken on this edge when valid is high |
| cmd_mode_i | input | 2 | Sync mode: 0 none, 1 rising TE, 2 falling TE, 3 reserved (as 0) |
| cmd_len_i | input | LEN_W (19) | Transfer length in bytes |
| cfg_ratio0_i | input | RATIO_W (4) | First prescaler stage exponent R0 |
| cfg_ratio1_i | input | RATIO_W (4) | Second prescaler stage exponent R1 |
| cfg_wait_i | input | WAIT_W (8) | Delay in second-stage ticks (WAIT) |
| xfer_start_o | output | 1 | One-cycle transfer-start strobe |
| xfer_len_o | output | LEN_W (19) | Length for the started transfer |
| busy_o | output | 1 | A synchronized command is waiting |

## Verification
The bench sweeps both edge modes over every pairing of R0 and R1 from 0 to 2 and WAIT from 0 to 3, with idle gaps of different lengths. It counts the exact number of clock edges from the pin change to the strobe. An off-by-one prescaler compare, a prescaler that is not cleared at the edge, or a missing WAIT = 0 bypass each shows up as a wrong cycle count. Two further checks target the edge logic. In one, a TE edge lands on the very edge that accepts the command; a gate that qualifies it starts many cycles early. In the other, the opposite edge arrives first; a detector with inverted polarity starts at the wrong edge. The bench also offers a second command while one is waiting. A gate that takes it anyway starts with the wrong length.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

    typedef enum logic [1:0] {
        SYNC_NONE = 2'd0,
        SYNC_RISE = 2'd1,
        SYNC_FALL = 2'd2,
        SYNC_RSVD = 2'd3
    } sync_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DELAY = 2'd2
    } gate_state_e;

endpackage

// File: rtl/te_edge_sync.sv
module te_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic te_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[SYNC_STAGES-2:0], te_i};
        s_d.prev = s_q.sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rise_o =  s_q.sh[SYNC_STAGES-1] & ~s_q.prev;
    assign fall_o = ~s_q.sh[SYNC_STAGES-1] &  s_q.prev;
endmodule

// File: rtl/te_prescaler.sv
module te_prescaler #(
    parameter int RATIO_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clr_i,
    input  logic [RATIO_W-1:0] ratio0_i,
    input  logic [RATIO_W-1:0] ratio1_i,
    output logic               tick_o
);
    localparam int CNT_W = (1 << RATIO_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] c0;
        logic [CNT_W-1:0] c1;
    } pre_t;

    pre_t p_d, p_q;
    logic [CNT_W-1:0] lim0, lim1;
    logic             tick0;

    always_comb begin
        lim0   = ~({CNT_W{1'b1}} << ratio0_i);
        lim1   = ~({CNT_W{1'b1}} << ratio1_i);
        tick0  = (p_q.c0 == lim0);
        tick_o = tick0 && (p_q.c1 == lim1);
        p_d    = p_q;
        if (clr_i) begin
            p_d = '0;
        end else begin
            p_d.c0 = tick0 ? '0 : p_q.c0 + CNT_W'(1);
            if (tick0) p_d.c1 = tick_o ? '0 : p_q.c1 + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end
endmodule

// File: rtl/te_sync_gate.sv
module te_sync_gate
    import te_sync_pkg::*;
#(
    parameter int LEN_W   = 19,
    parameter int RATIO_W = 4,
    parameter int WAIT_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               te_pin_i,
    input  logic               cmd_valid_i,
    output logic               cmd_ready_o,
    input  logic [1:0]         cmd_mode_i,
    input  logic [LEN_W-1:0]   cmd_len_i,
    input  logic [RATIO_W-1:0] cfg_ratio0_i,
    input  logic [RATIO_W-1:0] cfg_ratio1_i,
    input  logic [WAIT_W-1:0]  cfg_wait_i,
    output logic               xfer_start_o,
    output logic [LEN_W-1:0]   xfer_len_o,
    output logic               busy_o
);
    typedef struct packed {
        gate_state_e       st;
        sync_mode_e        mode;
        logic [WAIT_W-1:0] cnt;
        logic              start;
        logic [LEN_W-1:0]  len;
    } gate_t;

    gate_t g_d, g_q;
    logic  te_rise, te_fall, tick, clr, hit;

    te_edge_sync #(.SYNC_STAGES(2)) edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .te_i   (te_pin_i),
        .rise_o (te_rise),
        .fall_o (te_fall)
    );

    te_prescaler #(.RATIO_W(RATIO_W)) pre_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr),
        .ratio0_i (cfg_ratio0_i),
        .ratio1_i (cfg_ratio1_i),
        .tick_o   (tick)
    );

    always_comb begin
        g_d         = g_q;
        g_d.start   = 1'b0;
        clr         = 1'b0;
        hit         = (g_q.mode == SYNC_RISE) ? te_rise : te_fall;
        cmd_ready_o = (g_q.st == ST_IDLE);
        unique case (g_q.st)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    g_d.len  = cmd_len_i;
                    g_d.mode = sync_mode_e'(cmd_mode_i);
                    if (g_d.mode == SYNC_RISE || g_d.mode == SYNC_FALL)
                        g_d.st = ST_ARMED;
                    else
                        g_d.start = 1'b1;
                end
            end
            ST_ARMED: begin
                if (hit) begin
                    clr     = 1'b1;
                    g_d.cnt = '0;
                    if (cfg_wait_i == '0) begin
                        g_d.start = 1'b1;
                        g_d.st    = ST_IDLE;
                    end else begin
                        g_d.st = ST_DELAY;
                    end
                end
            end
            ST_DELAY: begin
                if (tick) begin
                    if (g_q.cnt + WAIT_W'(1) == cfg_wait_i) begin
                        g_d.start = 1'b1;
                        g_d.st    = ST_IDLE;
                    end else begin
                        g_d.cnt = g_q.cnt + WAIT_W'(1);
                    end
                end
            end
            default: g_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) g_q <= '{st: ST_IDLE, mode: SYNC_NONE, default: '0};
        else         g_q <= g_d;
    end

    assign xfer_start_o = g_q.start;
    assign xfer_len_o   = g_q.len;
    assign busy_o       = (g_q.st != ST_IDLE);
endmodule

// File: rtl/te_sync_gate_chk.sv
module te_sync_gate_chk #(
    parameter int LEN_W = 19
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cmd_valid_i,
    input logic             cmd_ready_o,
    input logic [1:0]       cmd_mode_i,
    input logic [LEN_W-1:0] cmd_len_i,
    input logic             xfer_start_o,
    input logic [LEN_W-1:0] xfer_len_o,
    input logic             busy_o
);
    AST_NOSYNC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_i && cmd_ready_o && (cmd_mode_i == 2'd0 || cmd_mode_i == 2'd3)
        |=> xfer_start_o && !busy_o && xfer_len_o == $past(cmd_len_i)); // R2

    AST_SYNC_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_i && cmd_ready_o && (cmd_mode_i == 2'd1 || cmd_mode_i == 2'd2)
        |=> busy_o && !xfer_start_o); // R4

    AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(xfer_len_o)); // R8

    AST_BUSY_ENDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> xfer_start_o); // R8

    AST_START_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_start_o |-> $past(busy_o) || $past(cmd_valid_i && cmd_ready_o)); // R9
endmodule

bind te_sync_gate te_sync_gate_chk #(.LEN_W(LEN_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_mode_i   (cmd_mode_i),
    .cmd_len_i    (cmd_len_i),
    .xfer_start_o (xfer_start_o),
    .xfer_len_o   (xfer_len_o),
    .busy_o       (busy_o)
);

// File: tb/te_sync_gate_tb_top.sv
module te_sync_gate_tb_top;
    localparam int LEN_W = 19;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             te_pin = 1'b0;
    logic             valid = 1'b0;
    logic             ready;
    logic [1:0]       mode = 2'd0;
    logic [LEN_W-1:0] len = '0;
    logic [3:0]       r0 = '0, r1 = '0;
    logic [7:0]       wt = '0;
    logic             start, busy;
    logic [LEN_W-1:0] xlen;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    te_sync_gate dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .te_pin_i     (te_pin),
        .cmd_valid_i  (valid),
        .cmd_ready_o  (ready),
        .cmd_mode_i   (mode),
        .cmd_len_i    (len),
        .cfg_ratio0_i (r0),
        .cfg_ratio1_i (r1),
        .cfg_wait_i   (wt),
        .xfer_start_o (start),
        .xfer_len_o   (xlen),
        .busy_o       (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic [LEN_W-1:0] l);
        @(negedge clk);
        valid = 1'b1; mode = m; len = l;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic wait_start(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (start) break;
        end
    endtask

    task automatic sync_run(input logic [1:0] m, input int a0, input int a1,
                            input int t, input int gap, input string req);
        int n, exp;
        exp = 3 + t * (1 << (a0 + a1));
        @(negedge clk);
        r0 = 4'(a0); r1 = 4'(a1); wt = 8'(t);
        te_pin = (m == 2'd2);
        repeat (gap + 4) @(negedge clk);
        send(m, LEN_W'(100 + t));
        check(busy && !start, "R8 busy after sync accept", int'(busy), 1);
        te_pin = ~te_pin;
        wait_start(exp + 6, n);
        check(start && n == exp, req, n, exp);
        check(xlen == LEN_W'(100 + t), "R9 length", int'(xlen), 100 + t);
        @(negedge clk);
        check(!start && !busy, "R9 single pulse", int'(start), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready && !busy && !start, "R1 reset state", int'({ready, busy, start}), 4);

        // R2: immediate start, back to back
        send(2'd0, LEN_W'(7));
        check(start && xlen == LEN_W'(7) && !busy, "R2 mode0 start", int'(xlen), 7);
        send(2'd0, LEN_W'(9));
        check(start && xlen == LEN_W'(9), "R2 back-to-back", int'(xlen), 9);
        // R3: reserved mode
        send(2'd3, LEN_W'(11));
        check(start && !busy, "R3 reserved as none", int'(start), 1);
        // R9: maximum length
        send(2'd0, LEN_W'(19'h40000));
        check(start && xlen == LEN_W'(19'h40000), "R9 max length", int'(xlen), 32'h40000);
        @(negedge clk);
        check(!start, "R9 pulse width", int'(start), 0);

        // R4/R5/R6/R10 sweep
        for (int m = 1; m <= 2; m++)
            for (int a0 = 0; a0 <= 2; a0++)
                for (int a1 = 0; a1 <= 2; a1++)
                    for (int t = 0; t <= 3; t++)
                        sync_run(2'(m), a0, a1, t, (a0 * 3 + a1 * 5 + t * 7) % 11,
                                 t == 0 ? "R6 zero wait" :
                                 (m == 1 ? "R4 rising delay" : "R5 falling delay"));
        sync_run(2'd1, 2, 2, 2, 37, "R10 long idle");

        // R7 stale edge on accept edge; R4 falling ignored
        @(negedge clk);
        r0 = 4'd0; r1 = 4'd0; wt = 8'd1;
        te_pin = 1'b0;
        repeat (5) @(negedge clk);
        te_pin = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        valid = 1'b1; mode = 2'd1; len = LEN_W'(55);
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        wait_start(12, n);
        check(!start, "R7 stale edge ignored", int'(start), 0);
        te_pin = 1'b0;
        wait_start(8, n);
        check(!start, "R4 falling edge ignored", int'(start), 0);
        te_pin = 1'b1;
        wait_start(12, n);
        check(start && n == 4, "R4 later rising edge", n, 4);

        // R5 rising edge ignored in falling mode
        @(negedge clk);
        te_pin = 1'b0;
        repeat (5) @(negedge clk);
        send(2'd2, LEN_W'(66));
        te_pin = 1'b1;
        wait_start(8, n);
        check(!start, "R5 rising edge ignored", int'(start), 0);
        te_pin = 1'b0;
        wait_start(12, n);
        check(start && n == 4, "R5 falling edge", n, 4);

        // R8 second command refused while waiting
        @(negedge clk);
        send(2'd1, LEN_W'(300));
        valid = 1'b1; mode = 2'd0; len = LEN_W'(301);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); @(negedge clk);
            check(!ready && busy && !start, "R8 not ready while busy", int'(ready), 0);
        end
        valid = 1'b0;
        te_pin = 1'b1;
        wait_start(12, n);
        check(start && xlen == LEN_W'(300), "R8 first command kept", int'(xlen), 300);
        @(negedge clk);
        check(!start && !busy && ready, "R8 idle afterwards", int'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule